// File: doc/BRIEF.md
# Write-Back Write-Allocate Second-Level Cache Controller

This block is a direct-mapped second-level cache controller. It sits between a write-through, no-allocate first-level cache and a word-wide main-memory port. Every store from the upper level reaches it, because the upper cache writes through. It accepts one request at a time: a word read, or a word write with byte enables. For each line it keeps a valid bit, a dirty bit and a tag.

A hit is answered one clock after the request is accepted, and a hit causes no memory traffic. On a miss, the current occupant of the line is examined first. If that line is valid and dirty, all of its words are written back to memory. The missing line is then fetched word by word, and the request is replayed as a hit. Writes therefore allocate, exactly as reads do. Main memory holds a stale value until the modified line is evicted.

Top module: `wbwa_cache`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid` and `mem_valid` are low, and every line is invalid, so the first access to any line misses.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the answer. Each request gets exactly one single-cycle `rsp_valid` pulse.
- R3: On a read hit, `rsp_valid` rises one clock after acceptance, carrying the stored word, and no memory transaction occurs.
- R4: On a read miss to an invalid or clean line, the controller performs LINE_WORDS memory reads at line offsets 0, 1, 2 and so on, in ascending order. It then returns the requested word. Addresses are word addresses: the offset is the low log2(LINE_WORDS) bits, the line index is the next log2(NUM_LINES) bits, and the tag is the remaining upper bits.
- R5: A write miss first fetches the whole line, then merges the write data into it. A later read of the same address returns the merged word.
- R6: When the line being replaced is valid and dirty, all LINE_WORDS of its words are written to memory, in ascending offset order and at the old tag's addresses. This happens before the first refill read.
- R7: A write hit, or a write that allocated its line, issues no memory write. Memory keeps its old value until that line is evicted. No memory transaction is issued while `req_ready` is high.
- R8: A clean victim is replaced with no memory write.
- R9: Bit i of `req_be` enables byte i (bits 8i+7 to 8i) of the write. Bytes whose enable bit is clear keep their previous value.
- R10: While `mem_valid` is high and `mem_ack` is low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged on the next cycle. Each `mem_ack` pulse completes one word transfer, and read data is taken from `mem_rdata` during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables for writes |
| rsp_valid | output | 1 | One-cycle answer pulse |
| rsp_rdata | output | DATA_W | Read data (valid for reads) |
| mem_valid | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Transfer complete |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench builds the controller with ADDR_W=10, NUM_LINES=4 and LINE_WORDS=4. With these values, two addresses 16 words apart land on the same line under different tags, so conflict evictions of both clean and dirty victims can be set up in a few accesses. The memory model answers each word after 3 cycles. This gives the hold rule of the memory port real stall cycles to act on. It also lets the bench count the write-back and refill beats of each miss, and check their order.

// File: rtl/wbwa_cache_pkg.sv
package wbwa_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FLUSH  = 2'd2,
        ST_FILL   = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/wbwa_tag_store.sv
module wbwa_tag_store #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] line_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag
);

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [TAG_W-1:0] tag;
    } meta_t;

    meta_t [NUM_LINES-1:0] meta_vec;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        meta_t meta_d;
        meta_t meta_q;

        always_comb begin
            meta_d = meta_q;
            if (wr_en && (line_idx == IDX_W'(l))) begin
                meta_d.valid = wr_valid;
                meta_d.dirty = wr_dirty;
                meta_d.tag   = wr_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= '0;
            end else begin
                meta_q <= meta_d;
            end
        end

        assign meta_vec[l] = meta_q;
    end

    assign rd_valid = meta_vec[line_idx].valid;
    assign rd_dirty = meta_vec[line_idx].dirty;
    assign rd_tag   = meta_vec[line_idx].tag;

endmodule

// File: rtl/wbwa_data_store.sv
module wbwa_data_store #(
    parameter int NUM_LINES  = 16,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 4,
    parameter int OFF_W      = 2
) (
    input  logic                  clk,
    input  logic [IDX_W-1:0]      line_idx,
    input  logic [OFF_W-1:0]      rd_off,
    output logic [DATA_W-1:0]     rd_word,
    input  logic                  wr_en,
    input  logic [OFF_W-1:0]      wr_off,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic [DATA_W-1:0]     wr_word
);

    localparam int LANES = DATA_W / 8;
    localparam int DEPTH = NUM_LINES * LINE_WORDS;
    localparam int SEL_W = IDX_W + OFF_W;

    logic [SEL_W-1:0] rd_sel;
    logic [SEL_W-1:0] wr_sel;

    assign rd_sel = {line_idx, rd_off};
    assign wr_sel = {line_idx, wr_off};

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) begin
                lane_q[wr_sel] <= wr_word[8*b +: 8];
            end
        end

        assign rd_word[8*b +: 8] = lane_q[rd_sel];
    end

endmodule

// File: rtl/wbwa_ctrl.sv
module wbwa_ctrl
    import wbwa_cache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int IDX_W      = 4,
    parameter int OFF_W      = 2,
    parameter int TAG_W      = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    // upper request side
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    // memory side
    output logic                mem_valid,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata,
    // line index shared by both stores
    output logic [IDX_W-1:0]    line_idx,
    // tag store
    input  logic                tg_valid,
    input  logic                tg_dirty,
    input  logic [TAG_W-1:0]    tg_tag,
    output logic                tg_we,
    output logic                tg_wvalid,
    output logic                tg_wdirty,
    output logic [TAG_W-1:0]    tg_wtag,
    // data store
    output logic [OFF_W-1:0]    dt_roff,
    input  logic [DATA_W-1:0]   dt_rword,
    output logic                dt_we,
    output logic [OFF_W-1:0]    dt_woff,
    output logic [DATA_W/8-1:0] dt_wbe,
    output logic [DATA_W-1:0]   dt_wword
);

    localparam int BE_W = DATA_W / 8;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

    typedef struct packed {
        ctl_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic                we;
        logic [DATA_W-1:0]   wdata;
        logic [BE_W-1:0]     be;
        logic [OFF_W-1:0]    beat;
        logic                rsp_v;
        logic [DATA_W-1:0]   rsp_d;
    } ctl_t;

    ctl_t s_d;
    ctl_t s_q;

    logic [TAG_W-1:0] cur_tag;
    logic [OFF_W-1:0] cur_off;
    logic             hit;

    assign line_idx = s_q.addr[OFF_W +: IDX_W];
    assign cur_tag  = s_q.addr[ADDR_W-1 -: TAG_W];
    assign cur_off  = s_q.addr[OFF_W-1:0];
    assign hit      = tg_valid && (tg_tag == cur_tag);

    always_comb begin
        s_d        = s_q;
        s_d.rsp_v  = 1'b0;

        req_ready  = 1'b0;
        mem_valid  = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        tg_we      = 1'b0;
        tg_wvalid  = 1'b0;
        tg_wdirty  = 1'b0;
        tg_wtag    = cur_tag;
        dt_roff    = (s_q.st == ST_FLUSH) ? s_q.beat : cur_off;
        dt_we      = 1'b0;
        dt_woff    = cur_off;
        dt_wbe     = '0;
        dt_wword   = s_q.wdata;

        unique case (s_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    s_d.addr  = req_addr;
                    s_d.we    = req_we;
                    s_d.wdata = req_wdata;
                    s_d.be    = req_be;
                    s_d.st    = ST_LOOKUP;
                end
            end

            ST_LOOKUP: begin
                if (hit) begin
                    s_d.rsp_v = 1'b1;
                    s_d.rsp_d = dt_rword;
                    if (s_q.we) begin
                        dt_we     = 1'b1;
                        dt_woff   = cur_off;
                        dt_wbe    = s_q.be;
                        dt_wword  = s_q.wdata;
                        tg_we     = 1'b1;
                        tg_wvalid = 1'b1;
                        tg_wdirty = 1'b1;
                        tg_wtag   = cur_tag;
                    end
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.beat = '0;
                    s_d.st   = (tg_valid && tg_dirty) ? ST_FLUSH : ST_FILL;
                end
            end

            ST_FLUSH: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tg_tag, line_idx, s_q.beat};
                mem_wdata = dt_rword;
                if (mem_ack) begin
                    s_d.beat = s_q.beat + 1'b1;
                    if (s_q.beat == LAST_BEAT) begin
                        s_d.beat = '0;
                        s_d.st   = ST_FILL;
                    end
                end
            end

            ST_FILL: begin
                mem_valid = 1'b1;
                mem_we    = 1'b0;
                mem_addr  = {cur_tag, line_idx, s_q.beat};
                if (mem_ack) begin
                    dt_we    = 1'b1;
                    dt_woff  = s_q.beat;
                    dt_wbe   = '1;
                    dt_wword = mem_rdata;
                    s_d.beat = s_q.beat + 1'b1;
                    if (s_q.beat == LAST_BEAT) begin
                        tg_we     = 1'b1;
                        tg_wvalid = 1'b1;
                        tg_wdirty = 1'b0;
                        tg_wtag   = cur_tag;
                        s_d.st    = ST_LOOKUP;
                    end
                end
            end

            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_v;
    assign rsp_rdata = s_q.rsp_d;

endmodule

// File: rtl/wbwa_cache.sv
module wbwa_cache #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_valid,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata
);

    localparam int BE_W  = DATA_W / 8;
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [IDX_W-1:0]  line_idx;
    logic              tg_valid;
    logic              tg_dirty;
    logic [TAG_W-1:0]  tg_tag;
    logic              tg_we;
    logic              tg_wvalid;
    logic              tg_wdirty;
    logic [TAG_W-1:0]  tg_wtag;
    logic [OFF_W-1:0]  dt_roff;
    logic [DATA_W-1:0] dt_rword;
    logic              dt_we;
    logic [OFF_W-1:0]  dt_woff;
    logic [BE_W-1:0]   dt_wbe;
    logic [DATA_W-1:0] dt_wword;

    wbwa_ctrl #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS),
        .IDX_W      (IDX_W),
        .OFF_W      (OFF_W),
        .TAG_W      (TAG_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .line_idx  (line_idx),
        .tg_valid  (tg_valid),
        .tg_dirty  (tg_dirty),
        .tg_tag    (tg_tag),
        .tg_we     (tg_we),
        .tg_wvalid (tg_wvalid),
        .tg_wdirty (tg_wdirty),
        .tg_wtag   (tg_wtag),
        .dt_roff   (dt_roff),
        .dt_rword  (dt_rword),
        .dt_we     (dt_we),
        .dt_woff   (dt_woff),
        .dt_wbe    (dt_wbe),
        .dt_wword  (dt_wword)
    );

    wbwa_tag_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_idx (line_idx),
        .rd_valid (tg_valid),
        .rd_dirty (tg_dirty),
        .rd_tag   (tg_tag),
        .wr_en    (tg_we),
        .wr_valid (tg_wvalid),
        .wr_dirty (tg_wdirty),
        .wr_tag   (tg_wtag)
    );

    wbwa_data_store #(
        .NUM_LINES  (NUM_LINES),
        .LINE_WORDS (LINE_WORDS),
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W),
        .OFF_W      (OFF_W)
    ) u_data (
        .clk      (clk),
        .line_idx (line_idx),
        .rd_off   (dt_roff),
        .rd_word  (dt_rword),
        .wr_en    (dt_we),
        .wr_off   (dt_woff),
        .wr_be    (dt_wbe),
        .wr_word  (dt_wword)
    );

endmodule

// File: rtl/wbwa_cache_chk.sv
module wbwa_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_valid,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    rsp_back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R7
    idle_no_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_valid);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_we)
                                     && $stable(mem_addr) && $stable(mem_wdata)));

endmodule

bind wbwa_cache wbwa_cache_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/wbwa_cache_test.sv
module wbwa_cache_test;

    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int WORDS = 4;
    localparam int LINES = 4;
    localparam int LAT   = 3;
    localparam int MSZ   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [3:0]    req_be = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          mem_valid;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #10 clk = ~clk;   // 50 MHz

    wbwa_cache #(.ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(WORDS), .NUM_LINES(LINES)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int acc_cyc = 0;
    int rsp_cyc = 0;

    function automatic logic [DW-1:0] init_val(int i);
        return 32'h1000_0000 + i * 32'h0001_0003;
    endfunction

    logic [DW-1:0] mem_model [MSZ];
    logic [DW-1:0] ref_mem   [MSZ];

    task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // memory model with fixed latency
    int wait_cnt = 0;
    int rd_beats = 0;
    int wr_beats = 0;
    bit order_bad = 1'b0;
    bit hold_bad = 1'b0;

    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_valid) begin
            if (wait_cnt == LAT - 1) begin
                mem_ack  <= 1'b1;
                wait_cnt <= 0;
                if (mem_we) begin
                    mem_model[mem_addr] <= mem_wdata;
                    if (rd_beats != 0 || int'(mem_addr[1:0]) != (wr_beats % WORDS))
                        order_bad = 1'b1;
                    wr_beats = wr_beats + 1;
                end else begin
                    mem_rdata <= mem_model[mem_addr];
                    if (int'(mem_addr[1:0]) != (rd_beats % WORDS))
                        order_bad = 1'b1;
                    rd_beats = rd_beats + 1;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // port hold observer
    logic          pv_q = 1'b0;
    logic          pa_q = 1'b0;
    logic [AW-1:0] paddr_q = '0;
    logic          pwe_q = 1'b0;
    always @(negedge clk) begin
        if (rst_n && pv_q && !pa_q)
            if (!mem_valid || mem_addr != paddr_q || mem_we != pwe_q) hold_bad = 1'b1;
        pv_q    <= mem_valid;
        pa_q    <= mem_ack;
        paddr_q <= mem_addr;
        pwe_q   <= mem_we;
    end

    // scoreboard
    typedef struct {
        bit            is_rd;
        logic [DW-1:0] data;
        string         lbl;
    } exp_t;
    exp_t exp_q[$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            rsp_cyc = cyc;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "response with nothing pending", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_rd)
                    check(rsp_rdata == e.data, e.lbl, "read data", rsp_rdata, e.data);
            end
        end
    end

    task automatic access(bit we, int addr, logic [DW-1:0] wd, logic [3:0] be,
                          int exp_rd, int exp_wr, int exp_lat, string lbl);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_beats  = 0;
        wr_beats  = 0;
        order_bad = 1'b0;
        e.is_rd = !we;
        e.lbl   = lbl;
        e.data  = ref_mem[addr];
        if (we) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) ref_mem[addr][8*b +: 8] = wd[8*b +: 8];
        end
        exp_q.push_back(e);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = AW'(addr);
        req_wdata = wd;
        req_be    = be;
        @(posedge clk);
        @(negedge clk);
        acc_cyc   = cyc;
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        if (exp_rd >= 0) check(rd_beats == exp_rd, lbl, "refill beats", rd_beats, exp_rd);
        if (exp_wr >= 0) check(wr_beats == exp_wr, lbl, "write-back beats", wr_beats, exp_wr);
        if (exp_rd >= 0) check(!order_bad, lbl, "beat order", order_bad, 0);
        if (exp_lat >= 0) check(rsp_cyc - acc_cyc == exp_lat, lbl, "hit latency",
                                rsp_cyc - acc_cyc, exp_lat);
    endtask

    initial begin
        for (int i = 0; i < MSZ; i++) begin
            mem_model[i] = init_val(i);
            ref_mem[i]   = init_val(i);
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(mem_valid == 1'b0, "R1", "mem_valid after reset", mem_valid, 0);

        // R1 / R4: first read misses, clean refill
        access(0, 'h005, 0, 4'h0, WORDS, 0, -1, "R4");
        // R3: read hit, one cycle, no traffic
        access(0, 'h006, 0, 4'h0, 0, 0, 1, "R3");
        // R7 / R9: partial write hit
        access(1, 'h007, 32'hDEADBEEF, 4'b0101, 0, 0, 1, "R7");
        access(0, 'h007, 0, 4'h0, 0, 0, 1, "R9");
        check(mem_model['h007] == init_val('h007), "R7", "memory stale after write hit",
              mem_model['h007], init_val('h007));
        // R5: write miss to invalid line allocates
        access(1, 'h022, 32'hCAFE0022, 4'hF, WORDS, 0, -1, "R5");
        access(0, 'h022, 0, 4'h0, 0, 0, 1, "R5");
        check(mem_model['h022] == init_val('h022), "R7", "memory stale after allocated write",
              mem_model['h022], init_val('h022));
        // R6: dirty victim written back before refill
        access(0, 'h045, 0, 4'h0, WORDS, WORDS, -1, "R6");
        check(mem_model['h007] == ref_mem['h007], "R6", "evicted word in memory",
              mem_model['h007], ref_mem['h007]);
        // R8: clean victim, no write-back
        access(0, 'h085, 0, 4'h0, WORDS, 0, -1, "R8");
        // R6: dirty allocated line evicted
        access(0, 'h002, 0, 4'h0, WORDS, WORDS, -1, "R6");
        check(mem_model['h022] == 32'hCAFE0022, "R6", "allocated write reaches memory",
              mem_model['h022], 32'hCAFE0022);
        // R5 / R9: partial write miss over clean victim
        access(1, 'h0A1, 32'h77AABBCC, 4'b1000, WORDS, 0, -1, "R5");
        access(0, 'h0A1, 0, 4'h0, 0, 0, 1, "R9");
        access(0, 'h021, 0, 4'h0, WORDS, WORDS, -1, "R6");
        check(mem_model['h0A1] == ref_mem['h0A1], "R6", "partial write evicted",
              mem_model['h0A1], ref_mem['h0A1]);

        // R2: mixed stream against the reference view
        begin
            logic [15:0] r = 16'hACE1;
            for (int n = 0; n < 60; n++) begin
                int a;
                r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
                a = ((int'(r[7:4]) % 3) * 16) + int'(r[3:0]);
                access(r[8], a, {r, r ^ 16'h5A5A}, r[12:9], -1, -1, -1, "R2");
            end
        end

        check(!hold_bad, "R10", "memory request held until ack", hold_bad, 0);
        check(exp_q.size() == 0, "R2", "all requests answered", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule